// File: doc/BRIEF.md
# Outstanding Line Request Tracker

This block sits between one core and its first-level cache controller and holds the cache lines of the memory requests still in flight. Each request arrives already classified as a load, a store, a locked read-modify-write read or a locked read-modify-write write. The block reduces the address to a line address and answers with one of three results: accepted, full or aliased. Loads go into a read table. All store-class kinds go into a separate write table. A second port takes completions, which remove a line from the read or the write table.

A line already held in either table refuses any new request to it, and the rejection is counted under one of four alias categories. When a locked read completes, its line is held locked, and only a locked write may enter it until that locked write completes too. Every entry is stamped with the cycle it entered. A deadlock flag latches as soon as any held entry has been outstanding for the threshold number of cycles.

Top module: `line_req_tracker`

## Requirements
- R1: When the outstanding count equals MAX_OUT, a request is answered full (`rsp_status` = 1). This test is made before the lock and alias tests, and a full answer changes no counter.
- R2: The `req_kind` encoding is 0 load, 1 store, 2 locked read, 3 locked write. A load that is not rejected enters the read table, and kinds 1 to 3 enter the write table. An accepted request is answered with `rsp_status` = 0. `rsp_valid` and `rsp_status` appear in the cycle after the request.
- R3: A store-class request whose line is in the read table or the write table is answered aliased (`rsp_status` = 2). A read-table hit increments `alias_st_ld`, and otherwise a write-table hit increments `alias_st_st`.
- R4: A load whose line is in the write table or the read table is answered aliased. A write-table hit increments `alias_ld_st`, and otherwise a read-table hit increments `alias_ld_ld`.
- R5: The completion of a locked-read entry locks its line. While the line is locked, every request to it except a locked write is answered aliased and changes no alias counter. The completion of a locked-write entry to that line removes the lock.
- R6: The four alias counters start at zero and wrap modulo 2^CNT_W. A request increments at most one of them.
- R7: `outstanding` equals the number of entries held in both tables. It rises by one on each accept and falls by one on each valid completion, and both can happen in the same cycle.
- R8: A completion whose line is absent from the table it names (`cpl_write` = 1 for the write table) raises `cpl_err` in the next cycle and changes no state.
- R9: `deadlock` rises one cycle after any held entry has been outstanding for THRESH cycles, and it stays high until reset. It never rises while both tables stay empty.
- R10: The line address is `req_addr` or `cpl_addr` with the low OFFS_W bits ignored, so two addresses that differ only in those bits refer to the same line.
- R11: A request is judged on the table and count state from before any completion arriving in the same cycle. A completing line therefore still aliases, and a full tracker still answers full.
- R12: After reset, all outputs are zero, both tables are empty and no line is locked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A new request is presented |
| req_kind | input | 2 | Request class: 0 load, 1 store, 2 locked read, 3 locked write |
| req_addr | input | ADDR_W | Request byte address |
| cpl_valid | input | 1 | A completion is presented |
| cpl_write | input | 1 | Completion targets the write table (1) or the read table (0) |
| cpl_addr | input | ADDR_W | Completion byte address |
| rsp_valid | output | 1 | Registered: a result for last cycle's request |
| rsp_status | output | 2 | 0 accepted, 1 full, 2 aliased |
| cpl_err | output | 1 | Registered: last completion matched no entry |
| outstanding | output | $clog2(MAX_OUT+1) | Entries held in both tables |
| alias_st_ld | output | CNT_W | Store rejected by a pending read |
| alias_st_st | output | CNT_W | Store rejected by a pending write |
| alias_ld_ld | output | CNT_W | Load rejected by a pending read |
| alias_ld_st | output | CNT_W | Load rejected by a pending write |
| deadlock | output | 1 | Sticky: an entry exceeded the age threshold |

## Verification
A request and a completion can land in the same cycle, and the completion may free exactly the line or the slot that the request needs. The bench provokes this on purpose. It fills the tracker and then offers a fresh line alongside a completion. It also offers the completing line itself alongside its own completion, and it scatters such pairs through a long pseudo-random sweep over eight lines. Each result is judged against a model that decides on the state before the edge and then applies both updates, so an early freeing of a slot shows up as a wrong status or a wrong count.

// File: rtl/lrt_pkg.sv
package lrt_pkg;
  typedef enum logic [1:0] {
    RSP_ACCEPT = 2'd0,
    RSP_FULL   = 2'd1,
    RSP_ALIAS  = 2'd2
  } rsp_e;

  typedef enum logic [1:0] {
    K_LOAD    = 2'd0,
    K_STORE   = 2'd1,
    K_LOCK_RD = 2'd2,
    K_LOCK_WR = 2'd3
  } kind_e;
endpackage

// File: rtl/lrt_cam.sv
module lrt_cam #(
  parameter int DEPTH  = 4,
  parameter int TAG_W  = 6,
  parameter int TS_W   = 16,
  parameter int THRESH = 200,
  localparam int OCC_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ins_en,
  input  logic [TAG_W-1:0] ins_tag,
  input  logic [1:0]       ins_kind,
  input  logic [TS_W-1:0]  now,
  input  logic [TAG_W-1:0] look_tag,
  output logic             look_hit,
  input  logic             rm_en,
  input  logic [TAG_W-1:0] rm_tag,
  output logic             rm_hit,
  output logic [1:0]       rm_kind,
  output logic [OCC_W-1:0] occ,
  output logic             aged
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DEPTH-1:0] vld;
  logic [TAG_W-1:0] tag_r  [DEPTH];
  logic [1:0]       kind_r [DEPTH];
  logic [TS_W-1:0]  ts_r   [DEPTH];

  logic [DEPTH-1:0] look_vec, rm_vec, age_vec;
  logic [IDX_W-1:0] free_idx;
  logic             have_free;

  always_comb begin
    free_idx  = '0;
    have_free = 1'b0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (!vld[i]) begin
        free_idx  = IDX_W'(i);
        have_free = 1'b1;
      end
    end
  end

  always_comb begin
    rm_kind = '0;
    occ     = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (rm_vec[i]) rm_kind = rm_kind | kind_r[i];
      occ = occ + OCC_W'(vld[i]);
    end
  end

  assign look_hit = |look_vec;
  assign rm_hit   = |rm_vec;
  assign aged     = |age_vec;

  genvar g;
  generate
    for (g = 0; g < DEPTH; g++) begin : g_slot
      logic [TS_W-1:0] age;
      assign age         = now - ts_r[g];
      assign look_vec[g] = vld[g] && (tag_r[g] == look_tag);
      assign rm_vec[g]   = vld[g] && (tag_r[g] == rm_tag);
      assign age_vec[g]  = vld[g] && (age >= TS_W'(THRESH));

      always_ff @(posedge clk) begin
        if (rst) begin
          vld[g]    <= 1'b0;
          tag_r[g]  <= '0;
          kind_r[g] <= '0;
          ts_r[g]   <= '0;
        end else begin
          if (rm_en && rm_vec[g]) vld[g] <= 1'b0;
          if (ins_en && have_free && (free_idx == IDX_W'(g))) begin
            vld[g]    <= 1'b1;
            tag_r[g]  <= ins_tag;
            kind_r[g] <= ins_kind;
            ts_r[g]   <= now;
          end
        end
      end
    end
  endgenerate

  // R3 R4: a line is never held twice in one table
  uniq_line_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(look_vec));

  // R7: an insert always finds a free slot
  ins_room_chk: assert property (@(posedge clk) disable iff (rst)
    ins_en |-> have_free);
endmodule

// File: rtl/line_req_tracker.sv
module line_req_tracker
  import lrt_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int OFFS_W  = 6,
  parameter int MAX_OUT = 8,
  parameter int THRESH  = 500,
  parameter int CNT_W   = 16,
  parameter int TS_W    = 16,
  localparam int CW     = $clog2(MAX_OUT + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [1:0]        req_kind,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              cpl_valid,
  input  logic              cpl_write,
  input  logic [ADDR_W-1:0] cpl_addr,
  output logic              rsp_valid,
  output logic [1:0]        rsp_status,
  output logic              cpl_err,
  output logic [CW-1:0]     outstanding,
  output logic [CNT_W-1:0]  alias_st_ld,
  output logic [CNT_W-1:0]  alias_st_st,
  output logic [CNT_W-1:0]  alias_ld_ld,
  output logic [CNT_W-1:0]  alias_ld_st,
  output logic              deadlock
);
  localparam int LINE_W = ADDR_W - OFFS_W;

  logic [LINE_W-1:0] req_line, cpl_line, lock_line_q;
  logic              lock_vld_q;
  logic [TS_W-1:0]   now_q;
  logic [CW-1:0]     count_q, rd_occ, wr_occ;
  logic              rd_look_hit, wr_look_hit, rd_rm_hit, wr_rm_hit;
  logic              rd_aged, wr_aged;
  logic [1:0]        rd_rm_kind, wr_rm_kind;
  logic              is_st, full_c, lock_blk, passed, accept, cpl_ok;
  logic              ins_rd, ins_wr, rm_rd, rm_wr;

  assign req_line = req_addr[ADDR_W-1:OFFS_W];
  assign cpl_line = cpl_addr[ADDR_W-1:OFFS_W];
  assign is_st    = (req_kind != K_LOAD);
  assign full_c   = (count_q >= CW'(MAX_OUT));
  assign lock_blk = lock_vld_q && (lock_line_q == req_line) && (req_kind != K_LOCK_WR);
  assign passed   = req_valid && !full_c && !lock_blk;
  assign accept   = passed && !rd_look_hit && !wr_look_hit;
  assign ins_rd   = accept && !is_st;
  assign ins_wr   = accept && is_st;
  assign rm_rd    = cpl_valid && !cpl_write;
  assign rm_wr    = cpl_valid && cpl_write;
  assign cpl_ok   = cpl_write ? (rm_wr && wr_rm_hit) : (rm_rd && rd_rm_hit);

  lrt_cam #(.DEPTH(MAX_OUT), .TAG_W(LINE_W), .TS_W(TS_W), .THRESH(THRESH)) u_rd_cam (
    .clk(clk), .rst(rst), .ins_en(ins_rd), .ins_tag(req_line), .ins_kind(req_kind),
    .now(now_q), .look_tag(req_line), .look_hit(rd_look_hit), .rm_en(rm_rd),
    .rm_tag(cpl_line), .rm_hit(rd_rm_hit), .rm_kind(rd_rm_kind), .occ(rd_occ),
    .aged(rd_aged));

  lrt_cam #(.DEPTH(MAX_OUT), .TAG_W(LINE_W), .TS_W(TS_W), .THRESH(THRESH)) u_wr_cam (
    .clk(clk), .rst(rst), .ins_en(ins_wr), .ins_tag(req_line), .ins_kind(req_kind),
    .now(now_q), .look_tag(req_line), .look_hit(wr_look_hit), .rm_en(rm_wr),
    .rm_tag(cpl_line), .rm_hit(wr_rm_hit), .rm_kind(wr_rm_kind), .occ(wr_occ),
    .aged(wr_aged));

  // Result, count, timebase and deadlock latch
  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid  <= 1'b0;
      rsp_status <= RSP_ACCEPT;
      cpl_err    <= 1'b0;
      count_q    <= '0;
      now_q      <= '0;
      deadlock   <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      if (full_c)      rsp_status <= RSP_FULL;
      else if (accept) rsp_status <= RSP_ACCEPT;
      else             rsp_status <= RSP_ALIAS;
      cpl_err  <= cpl_valid && !cpl_ok;
      count_q  <= count_q + CW'(accept) - CW'(cpl_ok);
      now_q    <= now_q + 1'b1;
      deadlock <= deadlock | rd_aged | wr_aged;
    end
  end

  // Line lock held between a locked read and its locked write
  always_ff @(posedge clk) begin
    if (rst) begin
      lock_vld_q  <= 1'b0;
      lock_line_q <= '0;
    end else if (cpl_ok && cpl_write) begin
      if (wr_rm_kind == K_LOCK_RD) begin
        lock_vld_q  <= 1'b1;
        lock_line_q <= cpl_line;
      end else if (wr_rm_kind == K_LOCK_WR && lock_line_q == cpl_line) begin
        lock_vld_q <= 1'b0;
      end
    end
  end

  // Alias event counters
  always_ff @(posedge clk) begin
    if (rst) begin
      alias_st_ld <= '0;
      alias_st_st <= '0;
      alias_ld_ld <= '0;
      alias_ld_st <= '0;
    end else if (passed) begin
      if (is_st) begin
        if (rd_look_hit)      alias_st_ld <= alias_st_ld + 1'b1;
        else if (wr_look_hit) alias_st_st <= alias_st_st + 1'b1;
      end else begin
        if (wr_look_hit)      alias_ld_st <= alias_ld_st + 1'b1;
        else if (rd_look_hit) alias_ld_ld <= alias_ld_ld + 1'b1;
      end
    end
  end

  assign outstanding = count_q;

  // R1
  full_first_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && count_q == CW'(MAX_OUT)) |=> (rsp_status == RSP_FULL));

  // R7
  occ_sum_chk: assert property (@(posedge clk) disable iff (rst)
    count_q == rd_occ + wr_occ);

  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    count_q <= CW'(MAX_OUT));

  // R8
  bad_cpl_chk: assert property (@(posedge clk) disable iff (rst)
    (cpl_valid && !cpl_ok && !accept) |=> $stable(count_q));

  // R9
  dl_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    deadlock |=> deadlock);
endmodule

// File: tb/line_req_tracker_bench.sv
module line_req_tracker_bench;
  localparam int AW = 8, OW = 2, MX = 4, TH = 200, CN = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 0, cpl_valid = 0, cpl_write = 0;
  logic [1:0] req_kind = 0;
  logic [AW-1:0] req_addr = 0, cpl_addr = 0;
  logic rsp_valid, cpl_err, deadlock;
  logic [1:0] rsp_status;
  logic [2:0] outstanding;
  logic [CN-1:0] alias_st_ld, alias_st_st, alias_ld_ld, alias_ld_st;

  always #5 clk = ~clk;

  line_req_tracker #(.ADDR_W(AW), .OFFS_W(OW), .MAX_OUT(MX), .THRESH(TH),
                     .CNT_W(CN), .TS_W(16)) u_line_req_tracker (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
    .req_addr(req_addr), .cpl_valid(cpl_valid), .cpl_write(cpl_write),
    .cpl_addr(cpl_addr), .rsp_valid(rsp_valid), .rsp_status(rsp_status),
    .cpl_err(cpl_err), .outstanding(outstanding), .alias_st_ld(alias_st_ld),
    .alias_st_st(alias_st_st), .alias_ld_ld(alias_ld_ld),
    .alias_ld_st(alias_ld_st), .deadlock(deadlock));

  int n_chk = 0, n_bad = 0, cyc = 0;
  string ctx = "";
  bit rv_[MX], wv_[MX];
  logic [5:0] rl_[MX], wl_[MX];
  logic [1:0] wk_[MX];
  int rt_[MX], wt_[MX];
  bit lk_v, e_dl;
  logic [5:0] lk_l;
  logic [CN-1:0] e_sl, e_ss, e_ll, e_ls;
  logic [31:0] lcg = 32'h1234_5678;

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, ctx, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    req_valid = 0;
    cpl_valid = 0;
    repeat (2) @(negedge clk);
    for (int i = 0; i < MX; i++) begin rv_[i] = 0; wv_[i] = 0; end
    lk_v = 0; e_dl = 0; e_sl = 0; e_ss = 0; e_ll = 0; e_ls = 0; cyc = 0;
    rst = 1'b0;
    ctx = "reset";
    // R12: reset state
    chk("R12", rsp_valid, 0);
    chk("R12", cpl_err, 0);
    chk("R12", outstanding, 0);
    chk("R12", alias_st_ld + alias_st_st + alias_ld_ld + alias_ld_st, 0);
    chk("R12", deadlock, 0);
  endtask

  task automatic step(bit rq, logic [1:0] k, logic [7:0] a, bit cv, bit cw, logic [7:0] ca);
    logic [5:0] ln = a[7:2], cl = ca[7:2];
    bit rh = 0, wh = 0, st = (k != 0), ok = 0, lb, acc;
    int cnt = 0, ci = -1, es;
    for (int i = 0; i < MX; i++) begin
      if (rv_[i]) begin
        cnt++;
        if (rl_[i] == ln) rh = 1;
        if (cv && !cw && rl_[i] == cl) ci = i;
        if (cyc - rt_[i] >= TH) e_dl = 1;
      end
      if (wv_[i]) begin
        cnt++;
        if (wl_[i] == ln) wh = 1;
        if (cv && cw && wl_[i] == cl) ci = i;
        if (cyc - wt_[i] >= TH) e_dl = 1;
      end
    end
    ok = cv && (ci >= 0);
    lb = lk_v && lk_l == ln && k != 3;
    acc = 0;
    if (cnt >= MX) es = 1;
    else if (lb) es = 2;
    else if (rh || wh) begin
      es = 2;
      if (rq) begin
        if (st) begin if (rh) e_sl++; else e_ss++; end
        else begin if (wh) e_ls++; else e_ll++; end
      end
    end else begin es = 0; acc = rq; end
    req_valid = rq; req_kind = k; req_addr = a;
    cpl_valid = cv; cpl_write = cw; cpl_addr = ca;
    @(posedge clk);
    if (ok) begin
      if (cw) begin
        wv_[ci] = 0;
        if (wk_[ci] == 2) begin lk_v = 1; lk_l = cl; end
        else if (wk_[ci] == 3 && lk_l == cl) lk_v = 0;
      end else rv_[ci] = 0;
    end
    if (acc) begin
      if (st) begin
        for (int i = 0; i < MX; i++)
          if (!wv_[i]) begin wv_[i] = 1; wl_[i] = ln; wk_[i] = k; wt_[i] = cyc; break; end
      end else begin
        for (int i = 0; i < MX; i++)
          if (!rv_[i]) begin rv_[i] = 1; rl_[i] = ln; rt_[i] = cyc; break; end
      end
    end
    cyc++;
    @(negedge clk);
    chk("R2", rsp_valid, rq);
    if (rq) begin
      if (es == 1) chk("R1", rsp_status, es);
      else if (lb) chk("R5", rsp_status, es);
      else if (es == 0) chk("R2", rsp_status, es);
      else if (st) chk("R3", rsp_status, es);
      else chk("R4", rsp_status, es);
    end
    chk("R8", cpl_err, cv && !ok);
    chk("R7", outstanding, cnt + int'(acc) - int'(ok));
    chk("R6", alias_st_ld, e_sl);
    chk("R6", alias_st_st, e_ss);
    chk("R6", alias_ld_ld, e_ll);
    chk("R6", alias_ld_st, e_ls);
    chk("R9", deadlock, e_dl);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL R12 watchdog: actual 0 expected 1");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    do_reset();
    // R2 R1: fill with loads, then a fifth request is full even when aliased
    ctx = "fill";
    for (int i = 0; i < 4; i++) step(1, 0, 8'(i * 4), 0, 0, 0);
    step(1, 1, 8'h40, 0, 0, 0);
    step(1, 0, 8'h00, 0, 0, 0);
    // R11: completion and request in the same cycle
    ctx = "R11 same-cycle full";
    step(1, 0, 8'h50, 1, 0, 8'h00);
    ctx = "R11 same-cycle alias";
    step(1, 0, 8'h04, 1, 0, 8'h04);
    // R10: offset bits ignored
    ctx = "R10 offset";
    step(1, 1, 8'h0B, 0, 0, 0);
    step(1, 0, 8'h0D, 1, 0, 8'h0F);
    // R8: absent completions
    ctx = "R8 absent";
    step(0, 0, 0, 1, 1, 8'h80);
    step(0, 0, 0, 1, 0, 8'h0C);
    step(0, 0, 0, 1, 0, 8'h08);
    step(0, 0, 0, 1, 1, 8'h0C);
    step(1, 1, 8'h34, 0, 0, 0);
    step(0, 0, 0, 1, 1, 8'h34);
    // R3 R4: cross-table aliasing
    ctx = "R3 R4 cross";
    step(1, 1, 8'h20, 0, 0, 0);
    step(1, 0, 8'h20, 0, 0, 0);
    step(1, 1, 8'h21, 0, 0, 0);
    step(1, 0, 8'h24, 0, 0, 0);
    step(1, 1, 8'h25, 0, 0, 0);
    step(1, 0, 8'h26, 1, 1, 8'h20);
    idle(2);
    step(0, 0, 0, 1, 0, 8'h24);
    // R5: lock lifecycle
    ctx = "R5 lock";
    step(1, 2, 8'h30, 0, 0, 0);
    step(0, 0, 0, 1, 1, 8'h30);
    step(1, 0, 8'h30, 0, 0, 0);
    step(1, 1, 8'h31, 0, 0, 0);
    step(1, 2, 8'h32, 0, 0, 0);
    step(1, 0, 8'h38, 0, 0, 0);
    step(1, 3, 8'h33, 0, 0, 0);
    step(1, 0, 8'h30, 0, 0, 0);
    step(0, 0, 0, 1, 1, 8'h30);
    step(1, 0, 8'h30, 0, 0, 0);
    step(0, 0, 0, 1, 0, 8'h30);
    step(0, 0, 0, 1, 0, 8'h38);
    // Sweep: pseudo-random traffic over eight lines
    ctx = "sweep";
    for (int s = 0; s < 3000; s++) begin
      logic [31:0] r;
      bit pcv, pcw;
      logic [7:0] pa, pca;
      int pick;
      lcg = lcg * 32'd1103515245 + 32'd12345;
      r = lcg >> 8;
      pa = {r[8], 3'b000, r[5:4], r[7:6]};
      pcv = r[9] | r[10];
      pcw = r[15];
      pca = {r[16], 3'b000, r[18:17], r[20:19]};
      if (r[12:11] != 0) begin
        pick = -1;
        for (int j = 0; j < 2 * MX; j++) begin
          int x = (int'(r[14:13]) + j) % (2 * MX);
          if (pick < 0) begin
            if (x < MX && rv_[x]) begin pick = x; pcw = 0; pca = {rl_[x], r[20:19]}; end
            else if (x >= MX && wv_[x-MX]) begin pick = x; pcw = 1; pca = {wl_[x-MX], r[20:19]}; end
          end
        end
      end
      step(r[0] | r[1], r[3:2], pa, pcv, pcw, pca);
    end
    // R9: empty tables never flag, a stuck entry does
    do_reset();
    ctx = "R9 empty";
    idle(TH + 10);
    ctx = "R9 aged";
    step(1, 0, 8'h44, 0, 0, 0);
    idle(TH + 5);
    step(0, 0, 0, 1, 0, 8'h44);
    idle(3);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule